// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

The block gathers 160 interrupt sources, organised as five sets of 32 bits, and presents them to a processor on two request lines. Each source arrives as a single-cycle pulse. The pulse is latched into a pending bit, which stays set until software clears it with a write-one-to-clear access. A fixed routing table places a small group of sources on a vectored path with fifteen priority levels. Each level has its own mask bit. Every other source goes to a flat path gated by per-bit enables.

The vectored path drives the high request line and reports the highest unmasked pending level as a vector number. The flat path drives the low request line. A global enable gates both lines. Software reaches the pending, enable and control words over a simple synchronous register bus with one cycle of read latency.

Top module: `tirq_ctrl`

## Requirements
- R1: The address is {kind[1:0], set[2:0]}. For kind 0 (pending) and kind 1 (enable), the set field must be 1 to 5. Writes with a set field of 0, 6 or 7 change nothing, and reads with those values return 0. Kind 2 selects the control word whatever the set field is.
- R2: A pulse on `src_pulse[(s-1)*32+b]` sets pending bit b of set s. A kind-0 read of set s returns that set's pending word.
- R3: A kind-0 write clears each pending bit whose data bit is 1. Bits written as 0 keep their value.
- R4: If a pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R5: Line number = set*32 + bit. The vectored levels are: lines 185 and 184 → 15, 190 → 14, 189 → 13, 50 → 4, 49 → 3, 59 → 2, 167 and 160 → 1. Several lines can share a level. Every other line is flat.
- R6: `irq_high` asserts only if some vectored source is pending and its level's bit in the control mask field [15:0] is set.
- R7: `irq_low` asserts only if some flat source is pending and its enable bit is set.
- R8: When the global enable (control bit 16) is 0, neither request line asserts.
- R9: `irq_vector` gives the highest level that has a pending, unmasked vectored source, or 0 if there is none. It does not depend on the global enable. A control read returns mask [15:0], enable [16], low flag [17], high flag [18] and vector [23:20]. All other bits read as 0.
- R10: After reset, all pending, enable and mask bits and the global enable are 0, and both request lines and the vector are 0.
- R11: The request lines and the vector are registered. They change one cycle after the pending bit that causes the change. Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 160 | Source pulses, index (set-1)*32+bit |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 5 | {kind, set} register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_high | output | 1 | Vectored-path request |
| irq_low | output | 1 | Flat-path request |
| irq_vector | output | 4 | Highest unmasked pending level |

## Verification
Assertions check on every cycle that pending bits never drop without a clear write, that a pulse always leaves its bit set, and that a cleared bit without a simultaneous pulse reads as 0. They also check that a cleared global enable silences both lines, and that a nonzero vector always corresponds to a level whose mask bit was set. The bench sweeps every one of the 160 sources through pulse, route, read-back and clear, and compares each result with a routing table of its own. Only those scenarios can show the level ordering between competing sources, shared levels, the invalid set addresses, and the exact one-cycle output latency.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int NSETS = 5;
  localparam int SET_W = 32;
  localparam int NLEV  = 16;
  localparam int LVL_W = 4;

  typedef enum logic [1:0] {
    K_PEND = 2'd0,
    K_EN   = 2'd1,
    K_CTRL = 2'd2,
    K_NONE = 2'd3
  } kind_e;

  // control word field positions
  localparam int CW_GEN  = 16;
  localparam int CW_LOW  = 17;
  localparam int CW_HIGH = 18;
  localparam int CW_VEC  = 20;

  // routing table: line = set*32 + bit; 0 means flat path
  function automatic logic [LVL_W-1:0] line_level(input int unsigned line);
    case (line)
      185, 184: line_level = 4'd15;
      190:      line_level = 4'd14;
      189:      line_level = 4'd13;
      50:       line_level = 4'd4;
      49:       line_level = 4'd3;
      59:       line_level = 4'd2;
      167, 160: line_level = 4'd1;
      default:  line_level = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/tirq_set_bank.sv
module tirq_set_bank #(
  parameter int SET_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] pulse,
  input  logic             clr_we,
  input  logic             en_we,
  input  logic [SET_W-1:0] wdata,
  output logic [SET_W-1:0] pend_q,
  output logic [SET_W-1:0] en_q
);
  logic [SET_W-1:0] clr_mask;

  assign clr_mask = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | pulse;
      if (en_we) en_q <= wdata;
    end
  end

  // R2 / R4: a pulse always leaves its bit set, even against a clear
  p_pulse_sticks_r4: assert property (@(posedge clk) disable iff (rst)
    (pulse != '0) |=> ((pend_q & $past(pulse)) == $past(pulse)));

  // R3: cleared bits without a pulse read 0
  p_clear_works_r3: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((pend_q & $past(wdata) & ~$past(pulse)) == '0));

  // R3: no bit drops without a clear write
  p_no_spurious_drop_r3: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((~pend_q & $past(pend_q)) == '0));
endmodule

// File: rtl/tirq_prio_enc.sv
module tirq_prio_enc #(
  parameter int NLEV  = 16,
  parameter int LVL_W = 4
) (
  input  logic [NLEV-1:0]  lvl_pend,
  output logic [LVL_W-1:0] vec
);
  always_comb begin
    vec = '0;
    for (int l = 1; l < NLEV; l++) begin
      if (lvl_pend[l]) vec = LVL_W'(l);
    end
  end
endmodule

// File: rtl/tirq_ctrl.sv
module tirq_ctrl #(
  parameter int NSETS = tirq_pkg::NSETS,
  parameter int SET_W = tirq_pkg::SET_W,
  parameter int NLEV  = tirq_pkg::NLEV,
  parameter int LVL_W = tirq_pkg::LVL_W,
  parameter int SEL_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSETS*SET_W-1:0] src_pulse,
  input  logic                   bus_wen,
  input  logic [SEL_W+1:0]       bus_addr,
  input  logic [SET_W-1:0]       bus_wdata,
  output logic [SET_W-1:0]       bus_rdata,
  output logic                   irq_high,
  output logic                   irq_low,
  output logic [LVL_W-1:0]       irq_vector
);
  import tirq_pkg::*;

  localparam int NSRC = NSETS * SET_W;

  kind_e            kind;
  logic [SEL_W-1:0] sel;
  logic             sel_ok;
  logic [NSRC-1:0]  pend_all;
  logic [NSRC-1:0]  en_all;
  logic [NLEV-1:0]  mask_q;
  logic             gen_q;
  logic [NLEV-1:0]  lvl_raw;
  logic [NLEV-1:0]  lvl_pend;
  logic             low_any;
  logic [LVL_W-1:0] vec_c;

  assign kind   = kind_e'(bus_addr[SEL_W+1:SEL_W]);
  assign sel    = bus_addr[SEL_W-1:0];
  assign sel_ok = (sel >= SEL_W'(1)) && (sel <= SEL_W'(NSETS));

  generate
    for (genvar s = 0; s < NSETS; s++) begin : g_set
      logic hit;
      assign hit = bus_wen && (sel == SEL_W'(s + 1));
      tirq_set_bank #(.SET_W(SET_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .pulse  (src_pulse[s*SET_W +: SET_W]),
        .clr_we (hit && (kind == K_PEND)),
        .en_we  (hit && (kind == K_EN)),
        .wdata  (bus_wdata),
        .pend_q (pend_all[s*SET_W +: SET_W]),
        .en_q   (en_all[s*SET_W +: SET_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      gen_q  <= 1'b0;
    end else if (bus_wen && kind == K_CTRL) begin
      mask_q <= bus_wdata[NLEV-1:0];
      gen_q  <= bus_wdata[CW_GEN];
    end
  end

  // route every source by the fixed table
  always_comb begin
    lvl_raw = '0;
    low_any = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (line_level(i + SET_W) != '0)
        lvl_raw[line_level(i + SET_W)] = lvl_raw[line_level(i + SET_W)] | pend_all[i];
      else
        low_any = low_any | (pend_all[i] & en_all[i]);
    end
  end

  assign lvl_pend = lvl_raw & mask_q;

  tirq_prio_enc #(.NLEV(NLEV), .LVL_W(LVL_W)) u_enc (
    .lvl_pend (lvl_pend),
    .vec      (vec_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_high   <= 1'b0;
      irq_low    <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_high   <= gen_q & (|lvl_pend);
      irq_low    <= gen_q & low_any;
      irq_vector <= vec_c;
    end
  end

  // register read path
  logic [SET_W-1:0] pend_sel, en_sel, ctrl_word;

  always_comb begin
    pend_sel = '0;
    en_sel   = '0;
    for (int s = 0; s < NSETS; s++) begin
      if (sel == SEL_W'(s + 1)) begin
        pend_sel = pend_all[s*SET_W +: SET_W];
        en_sel   = en_all[s*SET_W +: SET_W];
      end
    end
    ctrl_word = '0;
    ctrl_word[NLEV-1:0]            = mask_q;
    ctrl_word[CW_GEN]              = gen_q;
    ctrl_word[CW_LOW]              = irq_low;
    ctrl_word[CW_HIGH]             = irq_high;
    ctrl_word[CW_VEC +: LVL_W]     = irq_vector;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (kind)
        K_PEND:  bus_rdata <= sel_ok ? pend_sel : '0;
        K_EN:    bus_rdata <= sel_ok ? en_sel : '0;
        K_CTRL:  bus_rdata <= ctrl_word;
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R8: global enable off silences both lines on the next cycle
  p_gate_off_r8: assert property (@(posedge clk) disable iff (rst)
    !gen_q |=> (!irq_high && !irq_low));

  // R9: a high request always comes with a nonzero vector
  p_vec_with_high_r9: assert property (@(posedge clk) disable iff (rst)
    irq_high |-> (irq_vector != '0));

  // R6: a nonzero vector names a level whose mask bit was set
  p_vec_masked_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_vector == '0) || ((($past(mask_q) >> irq_vector) & NLEV'(1)) != '0)));
endmodule

// File: tb/tirq_ctrl_tb.sv
module tirq_ctrl_tb;
  localparam int NSRC = 160;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NSRC-1:0]  src_pulse = '0;
  logic             bus_wen = 1'b0;
  logic [4:0]       bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             irq_high, irq_low;
  logic [3:0]       irq_vector;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  tirq_ctrl u_dut (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_high(irq_high), .irq_low(irq_low), .irq_vector(irq_vector)
  );

  function automatic int exp_level(input int line);
    if (line == 184 || line == 185) return 15;
    if (line == 190) return 14;
    if (line == 189) return 13;
    if (line == 50)  return 4;
    if (line == 49)  return 3;
    if (line == 59)  return 2;
    if (line == 160 || line == 167) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = {k, s}; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] k, input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    bus_addr = {k, s};
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    src_pulse[idx] = 1'b1;
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R10 reset state
    chk("R10 irq_high", 32'(irq_high), 0);
    chk("R10 irq_low", 32'(irq_low), 0);
    chk("R10 vector", 32'(irq_vector), 0);
    rd(2'd2, 3'd0, rv); chk("R10 ctrl", rv, 0);
    rd(2'd0, 3'd1, rv); chk("R10 pend1", rv, 0);
    rd(2'd1, 3'd5, rv); chk("R10 en5", rv, 0);

    for (int s = 1; s <= 5; s++) wr(2'd1, 3'(s), 32'hFFFF_FFFF);
    wr(2'd2, 3'd0, 32'h0001_FFFF);

    // R11: low request lags the pending bit by one cycle
    pulse(1);
    chk("R11 low not yet", 32'(irq_low), 0);
    idle(1);
    chk("R11 low now", 32'(irq_low), 1);
    wr(2'd0, 3'd1, 32'h2);
    idle(1);

    // sweep all sources: R2 R5 R6 R7 R9 R3
    for (int s = 1; s <= 5; s++) begin
      for (int b = 0; b < 32; b++) begin
        int lv;
        lv = exp_level(s * 32 + b);
        pulse((s - 1) * 32 + b);
        idle(1);
        chk($sformatf("R6 high line %0d", s*32+b), 32'(irq_high), 32'(lv != 0));
        chk($sformatf("R7 low line %0d", s*32+b), 32'(irq_low), 32'(lv == 0));
        chk($sformatf("R5 R9 vector line %0d", s*32+b), 32'(irq_vector), 32'(lv));
        rd(2'd0, 3'(s), rv);
        chk($sformatf("R2 pend line %0d", s*32+b), rv, 32'(1) << b);
        wr(2'd0, 3'(s), 32'(1) << b);
        idle(1);
        chk($sformatf("R3 cleared line %0d", s*32+b), {30'd0, irq_high, irq_low}, 0);
      end
    end

    // R3: zeros in a clear write keep bits
    pulse(32 + 3);
    wr(2'd0, 3'd2, 32'hFFFF_FFF7);
    rd(2'd0, 3'd2, rv); chk("R3 zero keeps", rv, 32'h8);
    wr(2'd0, 3'd2, 32'h8);

    // R4: pulse and clear in the same cycle
    @(negedge clk);
    src_pulse[64 + 9] = 1'b1;
    bus_wen = 1'b1; bus_addr = {2'd0, 3'd3}; bus_wdata = 32'h200;
    @(negedge clk);
    src_pulse = '0; bus_wen = 1'b0;
    rd(2'd0, 3'd3, rv); chk("R4 kept", rv, 32'h200);
    wr(2'd0, 3'd3, 32'h200);

    // R9 / R6: competing levels and masking
    pulse(128 + 25);
    pulse(27);
    idle(1);
    chk("R9 top level", 32'(irq_vector), 15);
    wr(2'd0, 3'd5, 32'(1) << 25);
    idle(1);
    chk("R9 next level", 32'(irq_vector), 2);
    wr(2'd2, 3'd0, 32'h0001_FFFB);
    idle(1);
    chk("R6 masked vector", 32'(irq_vector), 0);
    chk("R6 masked high", 32'(irq_high), 0);
    wr(2'd2, 3'd0, 32'h0001_FFFF);
    wr(2'd0, 3'd1, 32'(1) << 27);

    // R5: shared level
    pulse(128 + 24);
    pulse(128 + 25);
    wr(2'd0, 3'd5, 32'(1) << 25);
    idle(1);
    chk("R5 shared level", 32'(irq_vector), 15);
    wr(2'd0, 3'd5, 32'(1) << 24);

    // R8 / R9: global enable gating and control layout
    pulse(96);
    pulse(128 + 30);
    wr(2'd2, 3'd0, 32'h0000_FFFF);
    idle(1);
    chk("R8 high gated", 32'(irq_high), 0);
    chk("R8 low gated", 32'(irq_low), 0);
    chk("R9 vector ungated", 32'(irq_vector), 14);
    rd(2'd2, 3'd0, rv); chk("R9 ctrl gated", rv, 32'h00E0_FFFF);
    wr(2'd2, 3'd0, 32'h0001_FFFF);
    idle(1);
    chk("R8 high on", 32'(irq_high), 1);
    chk("R8 low on", 32'(irq_low), 1);
    rd(2'd2, 3'd0, rv); chk("R9 ctrl live", rv, 32'h00E7_FFFF);
    wr(2'd0, 3'd4, 32'h1);
    wr(2'd0, 3'd5, 32'(1) << 30);

    // R7: per-bit enable
    wr(2'd1, 3'd4, 32'h0);
    pulse(96 + 5);
    idle(1);
    chk("R7 disabled", 32'(irq_low), 0);
    rd(2'd0, 3'd4, rv); chk("R7 still pending", rv, 32'h20);
    wr(2'd1, 3'd4, 32'h20);
    idle(1);
    chk("R7 enabled", 32'(irq_low), 1);
    wr(2'd0, 3'd4, 32'h20);

    // R1: invalid set fields
    wr(2'd1, 3'd0, 32'h1234);
    wr(2'd1, 3'd6, 32'h1234);
    wr(2'd1, 3'd7, 32'h1234);
    rd(2'd1, 3'd0, rv); chk("R1 en set0", rv, 0);
    rd(2'd1, 3'd6, rv); chk("R1 en set6", rv, 0);
    rd(2'd1, 3'd7, rv); chk("R1 en set7", rv, 0);
    rd(2'd1, 3'd1, rv); chk("R1 en set1 intact", rv, 32'hFFFF_FFFF);
    pulse(0);
    wr(2'd0, 3'd0, 32'hFFFF_FFFF);
    wr(2'd0, 3'd7, 32'hFFFF_FFFF);
    rd(2'd0, 3'd1, rv); chk("R1 pend set1 intact", rv, 32'h1);
    rd(2'd0, 3'd0, rv); chk("R1 pend set0", rv, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule